// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received Ethernet frames in a circular area of packet memory. The area is divided into 256-byte pages. Two configuration inputs give its first page and its end page; the end page is exclusive. A current-page register marks where the next frame goes. The host owns a boundary page, which marks the oldest page it has not yet read.

A frame begins with a one-cycle start pulse that carries its byte count. The block then checks the free space between the current page and the boundary. If the ring cannot hold a maximum-size frame plus its header, or if the receiver is halted, the frame is dropped. Its bytes are then ignored.

An accepted frame is written starting at byte 4 of the current page. Frames shorter than the minimum are padded with zero bytes. When the write address reaches the end of the ring, it continues at the ring's first byte. A 4-byte header is then written at the start of the frame's first page. Finally, the current page moves to the next free page and a sticky receive interrupt bit is set.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the block is idle (`busy`=0), issues no memory write, `rx_irq`=0 and `cur_page`=0.
- R2: The free space is computed in bytes, with C = `cur_page`*256 and B = `host_bound`*256. If C < B it is B - C. Otherwise it is (`ring_last` - `ring_first`)*256 - (C - B). A frame is accepted only when the free space is at least 1518. A dropped frame writes nothing, leaves `cur_page` unchanged and does not set `rx_irq`.
- R3: A frame shorter than 60 bytes is stored as 60 bytes, with zero bytes after its own data. The padded length P is max(length, 60).
- R4: Frame data is written in arrival order, starting at address `cur_page`*256+4. It is followed by a header at offsets 0..3 of that page, written in this order:
  - byte 0, status: bit 0 = 1; bit 5 = bit 0 of the first frame byte; all other bits 0.
  - byte 1: the next page.
  - byte 2: the low byte of P+4.
  - byte 3: the high byte of P+4.
- R5: When the data write address would reach `ring_last`*256, the next byte goes to `ring_first`*256 instead.
- R6: The next page is N = `cur_page` + floor((P+4+4+255)/256). If N >= `ring_last`, then (`ring_last` - `ring_first`) is subtracted from N.
- R7: In the cycle after the last header byte is written, `cur_page` holds the next page and `rx_irq` is 1. `rx_irq_clr` clears `rx_irq`. If a set and a clear fall in the same cycle, the set wins.
- R8: A start pulse while `halt` is 1 is dropped, with the same effect as a drop for lack of space.
- R9: `cur_ld` loads `cur_ld_page` into `cur_page` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Receiver halted; new frames are dropped |
| ring_first | input | 8 | First page of the ring |
| ring_last | input | 8 | End page of the ring (exclusive) |
| host_bound | input | 8 | Host boundary page |
| cur_ld | input | 1 | Load the current page |
| cur_ld_page | input | 8 | Value for the load |
| frm_start | input | 1 | Frame start pulse |
| frm_len | input | LEN_W | Frame byte count, valid with `frm_start` |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| busy | output | 1 | A frame is being stored |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| rx_irq | output | 1 | Sticky frame-received status bit |
| rx_irq_clr | input | 1 | Clear `rx_irq` |
| cur_page | output | 8 | Current page |

## Verification
The assertions check these properties on every cycle:
- every memory write falls inside the ring;
- the next-page byte of the header lies inside the ring;
- padding bytes are zero;
- a halted start never makes the block busy;
- completion always moves the current page and raises the interrupt.

Only the bench scenarios can show the following:
- the exact byte sequence and addresses of a frame;
- the header contents;
- the free-space threshold at exactly 1518 bytes, with one case on each side;
- the data split across the ring wrap;
- that a dropped frame leaves the pointer and interrupt untouched.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int LEN_W     = 11,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  parameter int OK_BIT    = 0,
  parameter int GRP_BIT   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [7:0]       ring_first,
  input  logic [7:0]       ring_last,
  input  logic [7:0]       host_bound,
  input  logic             cur_ld,
  input  logic [7:0]       cur_ld_page,
  input  logic             frm_start,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             busy,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             rx_irq,
  input  logic             rx_irq_clr,
  output logic [7:0]       cur_page
);
  localparam int HDR_B = 4;
  localparam logic [16:0] NEED = 17'(MAX_FRAME + HDR_B);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_HDR} st_t;
  st_t st;

  logic [15:0]      wptr;
  logic [LEN_W-1:0] cnt, flen, plen;
  logic [15:0]      stored;
  logic [7:0]       nxt;
  logic [1:0]       hidx;
  logic             grp;

  // free space and drop decision
  logic [16:0] idx_b, bnd_b, ring_b, free_b;
  logic        full;
  assign idx_b  = {1'b0, cur_page, 8'h00};
  assign bnd_b  = {1'b0, host_bound, 8'h00};
  assign ring_b = {1'b0, ring_last - ring_first, 8'h00};
  assign free_b = (cur_page < host_bound) ? bnd_b - idx_b : ring_b - (idx_b - bnd_b);
  assign full   = free_b < NEED;

  // padded length and next page
  logic [LEN_W-1:0] plen_c;
  logic [15:0]      pages_c;
  logic [8:0]       nraw;
  logic [7:0]       next_c;
  assign plen_c  = (frm_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : frm_len;
  assign pages_c = (16'(plen_c) + 16'(HDR_B) + 16'(HDR_B) + 16'd255) >> 8;
  assign nraw    = {1'b0, cur_page} + pages_c[8:0];
  assign next_c  = (nraw >= {1'b0, ring_last}) ? 8'(nraw - {1'b0, ring_last - ring_first}) : nraw[7:0];

  // data path
  logic        real_b, wr_data;
  logic [15:0] wnext;
  logic [7:0]  status;
  assign real_b  = cnt < flen;
  assign wr_data = (st == S_DATA) && (real_b ? in_valid : 1'b1);
  assign wnext   = (wptr + 16'd1 == {ring_last, 8'h00}) ? {ring_first, 8'h00} : wptr + 16'd1;
  assign status  = 8'(1 << OK_BIT) | (8'(grp) << GRP_BIT);

  assign busy   = st != S_IDLE;
  assign mem_we = wr_data || (st == S_HDR);

  always_comb begin
    mem_addr  = wptr;
    mem_wdata = real_b ? in_data : 8'h00;
    if (st == S_HDR) begin
      mem_addr = {cur_page, 6'd0, hidx};
      case (hidx)
        2'd0:    mem_wdata = status;
        2'd1:    mem_wdata = nxt;
        2'd2:    mem_wdata = stored[7:0];
        default: mem_wdata = stored[15:8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_page <= 8'h00;
      rx_irq   <= 1'b0;
      wptr     <= '0;
      cnt      <= '0;
      flen     <= '0;
      plen     <= '0;
      stored   <= '0;
      nxt      <= '0;
      hidx     <= '0;
      grp      <= 1'b0;
    end else begin
      if (rx_irq_clr) rx_irq <= 1'b0;
      if (cur_ld)     cur_page <= cur_ld_page;
      case (st)
        S_IDLE: if (frm_start && !halt && !full) begin
          st     <= S_DATA;
          wptr   <= {cur_page, 8'd4};
          cnt    <= '0;
          flen   <= frm_len;
          plen   <= plen_c;
          stored <= 16'(plen_c) + 16'(HDR_B);
          nxt    <= next_c;
          grp    <= 1'b0;
        end
        S_DATA: if (wr_data) begin
          wptr <= wnext;
          cnt  <= cnt + 1'b1;
          if (cnt == '0) grp <= mem_wdata[0];
          if (cnt == plen - 1'b1) begin
            st   <= S_HDR;
            hidx <= 2'd0;
          end
        end
        default: begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            st       <= S_IDLE;
            cur_page <= nxt;
            rx_irq   <= 1'b1;
          end
        end
      endcase
    end
  end

  assert_ring_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= {ring_first, 8'h00}) && (mem_addr < {ring_last, 8'h00}));

  assert_next_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && hidx == 2'd1) |-> (mem_wdata >= ring_first) && (mem_wdata < ring_last));

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !real_b) |-> mem_we && mem_wdata == 8'h00);

  assert_halt_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frm_start && halt) |=> !busy);

  assert_done_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && hidx == 2'd3) |=> rx_irq && !busy && cur_page == $past(nxt));
endmodule

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
  logic clk = 0, rst_n = 0, halt = 0;
  logic [7:0] ring_first = 8'h40, ring_last = 8'h80, host_bound = 8'h40;
  logic cur_ld = 0; logic [7:0] cur_ld_page = 0;
  logic frm_start = 0; logic [10:0] frm_len = 0;
  logic in_valid = 0; logic [7:0] in_data = 0;
  logic busy, mem_we, rx_irq, rx_irq_clr = 0;
  logic [15:0] mem_addr; logic [7:0] mem_wdata, cur_page;

  rx_ring_writer dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0, exp_irq = 0;
  logic [7:0] exp_cur = 0;
  logic [15:0] qa[$]; logic [7:0] qd[$]; string qt[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops expected writes and compares
  initial forever begin
    @(negedge clk); #5;
    if (rst_n && mem_we) begin
      if (qa.size() == 0) chk(0, "R2", "unexpected write addr", mem_addr, 0);
      else begin
        logic [15:0] a; logic [7:0] d; string t;
        a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
        chk(mem_addr == a, t, "write addr", mem_addr, a);
        chk(mem_wdata == d, t, "write data", mem_wdata, d);
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finish_run();
  end

  task automatic settle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk); #5;
  endtask

  task automatic load_cur(input logic [7:0] p);
    @(negedge clk); cur_ld = 1; cur_ld_page = p;
    @(negedge clk); cur_ld = 0; #5;
    chk(cur_page == p, "R9", "cur_page after load", cur_page, p);
    exp_cur = p;
  endtask

  task automatic send(input int len, input logic [7:0] first, input string tag);
    int c, b, fr, plen, tot, nx;
    logic [15:0] a;
    bit acc;
    logic [7:0] d [];
    d = new[len];
    for (int i = 0; i < len; i++) d[i] = (i == 0) ? first : 8'((i * 7 + len) & 8'hff);
    c = exp_cur * 256; b = host_bound * 256;
    fr = (c < b) ? b - c : (ring_last - ring_first) * 256 - (c - b);
    acc = !halt && fr >= 1518;
    plen = (len < 60) ? 60 : len; tot = plen + 4;
    nx = exp_cur + (tot + 4 + 255) / 256;
    if (nx >= ring_last) nx -= ring_last - ring_first;
    if (acc) begin
      a = 16'(c + 4);
      for (int i = 0; i < plen; i++) begin
        qa.push_back(a); qd.push_back(i < len ? d[i] : 8'h00);
        qt.push_back(i < len ? tag : "R3");
        a = (a + 16'd1 == {ring_last, 8'h00}) ? {ring_first, 8'h00} : a + 16'd1;
      end
      for (int h = 0; h < 4; h++) begin
        qa.push_back(16'(c + h)); qt.push_back("R4");
        qd.push_back(h == 0 ? (8'h01 | (first[0] ? 8'h20 : 8'h00)) : h == 1 ? 8'(nx) :
                     h == 2 ? 8'(tot) : 8'(tot >> 8));
      end
    end
    @(negedge clk); frm_start = 1; frm_len = 11'(len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); frm_start = 0; in_valid = 1; in_data = d[i];
    end
    @(negedge clk); frm_start = 0; in_valid = 0;
    settle();
    if (acc) begin exp_cur = 8'(nx); exp_irq = 1; end
    chk(qa.size() == 0, tag, "pending writes", qa.size(), 0);
    chk(cur_page == exp_cur, acc ? "R6" : "R2", "cur_page", cur_page, exp_cur);
    chk(rx_irq == exp_irq, acc ? "R7" : "R2", "rx_irq", rx_irq, exp_irq);
  endtask

  task automatic clear_irq();
    @(negedge clk); rx_irq_clr = 1;
    @(negedge clk); rx_irq_clr = 0; #5;
    exp_irq = 0;
    chk(rx_irq == 0, "R7", "rx_irq after clear", rx_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk); #5;
    chk(busy == 0, "R1", "busy at reset", busy, 0);
    chk(mem_we == 0, "R1", "mem_we at reset", mem_we, 0);
    chk(rx_irq == 0, "R1", "rx_irq at reset", rx_irq, 0);
    chk(cur_page == 0, "R1", "cur_page at reset", cur_page, 0);
    @(negedge clk); rst_n = 1;
    load_cur(8'h40);
    send(20, 8'h02, "R3");
    clear_irq();
    send(100, 8'h01, "R4");
    send(300, 8'h10, "R6");
    clear_irq();
    host_bound = 8'h50;
    load_cur(8'h7F);
    send(600, 8'hFF, "R5");
    clear_irq();
    host_bound = 8'h47;
    send(70, 8'h03, "R2");
    host_bound = 8'h48;
    send(70, 8'h03, "R2");
    clear_irq();
    host_bound = 8'h40;
    halt = 1;
    send(64, 8'h00, "R8");
    halt = 0;
    send(1514, 8'h00, "R4");
    finish_run();
  end
endmodule